// File: doc/BRIEF.md
# Slave-Mode Peripheral Interrupt Controller

This block collects interrupt requests from five on-chip sources: three timers and two DMA channels. It picks the most urgent one and raises a single request line towards an external master interrupt controller. With the request it presents an 8-bit type code. The upper five bits of the code come from a programmable vector base. The lower three bits are a fixed code for each source. The block has no external interrupt inputs.

Software configures the block through a small memory-mapped register file. Each source has a control word that holds its priority level and its mask bit. A shared mask register, a priority threshold, a hold bit and the vector base complete the configuration. Read-only views of the pending and in-service bits are provided, together with a write-only specific end-of-interrupt port.

When the master acknowledges, the winning source is marked in service and its pending bit is dropped. From then on, only sources of equal or better level may raise the line again, so interrupts can nest. The controller acts only while the slave-mode select input is high, and that input is low out of reset.

Top module: `slave_intc`

## Requirements
- R1: After reset, irq_out and int_type are 0. Each control word reads 0x000F (level 7, masked). The mask register reads 0x1F. The threshold reads 7. The vector, request and in-service registers read 0.
- R2: While slave_en is low, irq_out stays low and ack has no effect on the in-service register.
- R3: A one-cycle pulse on src_req[i] sets pending bit i, which is readable at offset 0x2E bit i. Only an acknowledge of that source clears it, and the bit is kept while the source is blocked.
- R4: Source indices are 0 = timer 0, 1 = DMA 0, 2 = DMA 1, 3 = timer 1 and 4 = timer 2. Their fixed codes are 000, 010, 011, 100 and 101 respectively. int_type = {vector[7:3], code}, with the vector register at offset 0x20 and bits 2:0 reading 0.
- R5: The control word of source i is at offset 0x32 + 2·i. Bits 2:0 hold the level (0 is most urgent) and bit 3 is the mask. Among eligible sources, the lowest level wins.
- R6: Mask register bits 4:0 at offset 0x28 mirror control-word bit 3, and writing either place updates both. A masked source never raises irq_out.
- R7: The threshold is in bits 2:0 at offset 0x2A. A source whose level is numerically greater than the threshold is blocked.
- R8: An ack while slave_en and irq_out are high sets the winner's in-service bit (offset 0x2C), clears its pending bit, and drops irq_out on the same edge.
- R9: While any source is in service, only sources with a level less than or equal to the smallest in-service level may raise irq_out.
- R10: A write of a 3-bit code to offset 0x22 clears the in-service bit of the source with that code. Codes that belong to no source change nothing, and the offset reads 0.
- R11: Status bit 0 at offset 0x30 is a hold bit. While it is 1, irq_out is low and pending bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_en | input | 1 | Slave-mode select; low after reset |
| src_req | input | 5 | Request pulses from the internal sources, indexed as in R4 |
| ack | input | 1 | Acknowledge strobe from the master controller |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered one cycle after rd_en |
| irq_out | output | 1 | Registered request to the master controller |
| int_type | output | 8 | Registered type code of the current winner |

## Verification
A request pulse is latched on the first edge and shows on irq_out and int_type at the second edge. A register write, an end-of-interrupt write or a change of slave_en affects irq_out at the first edge after the strobe. An acknowledge drops irq_out on the edge that takes it. Read data is valid one edge after rd_en. The bench drives inputs and samples outputs on falling edges, and waits exactly those counts of edges before each comparison. The bench sweeps every source across several vector bases and every rotation of the priority assignment, and walks each rotation through the full acknowledge and end-of-interrupt sequence.

// File: rtl/slave_intc_pkg.sv
package slave_intc_pkg;
  localparam int NSRC    = 5;
  localparam int PRIO_W  = 3;
  localparam int CODE_W  = 3;
  localparam int VBASE_W = 5;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int TYPE_W  = VBASE_W + CODE_W;

  localparam logic [ADDR_W-1:0] OFF_VEC    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_EOI    = 8'h22;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_THR    = 8'h2A;
  localparam logic [ADDR_W-1:0] OFF_INSV   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h2E;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_CTL0   = 8'h32;

  typedef logic [PRIO_W-1:0] level_t;
  typedef logic [CODE_W-1:0] code_t;

  // fixed low bits of the type code per source index
  function automatic code_t src_code(input int idx);
    case (idx)
      0:       return 3'b000;
      1:       return 3'b010;
      2:       return 3'b011;
      3:       return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
    return ADDR_W'(int'(OFF_CTL0) + 2 * idx);
  endfunction
endpackage

// File: rtl/slave_intc_arb.sv
module slave_intc_arb
  import slave_intc_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         pend,
  input  logic [N-1:0]         insv,
  input  logic [N-1:0]         mask,
  input  logic [N-1:0][PW-1:0] level,
  input  logic [PW-1:0]        thr,
  input  logic                 hold,
  input  logic                 enable,
  output logic                 fire,
  output logic [IW-1:0]        win_idx
);
  logic [N-1:0] elig;
  logic [PW:0]  best_lvl;
  logic [PW:0]  nest_lvl;
  logic         found;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_elig
      assign elig[g] = pend[g] && !mask[g] && (level[g] <= thr);
    end
  endgenerate

  // lowest level wins; on a tie the lower index wins
  always_comb begin
    best_lvl = {1'b1, {PW{1'b0}}};
    win_idx  = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && ({1'b0, level[i]} < best_lvl)) begin
        best_lvl = {1'b0, level[i]};
        win_idx  = IW'(i);
        found    = 1'b1;
      end
    end
  end

  // most urgent level currently in service sets the nesting floor
  always_comb begin
    nest_lvl = {1'b1, {PW{1'b0}}};
    for (int i = 0; i < N; i++) begin
      if (insv[i] && ({1'b0, level[i]} < nest_lvl)) begin
        nest_lvl = {1'b0, level[i]};
      end
    end
  end

  assign fire = enable && !hold && found && (best_lvl <= nest_lvl);
endmodule

// File: rtl/slave_intc_regs.sv
module slave_intc_regs
  import slave_intc_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  parameter int VW = VBASE_W,
  parameter int CW = CODE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [N-1:0]         pend,
  input  logic [N-1:0]         insv,
  output logic [N-1:0][PW-1:0] level,
  output logic [N-1:0]         mask,
  output logic [PW-1:0]        thr,
  output logic                 hold,
  output logic [VW-1:0]        vbase,
  output logic                 eoi_v,
  output logic [CW-1:0]        eoi_code,
  output logic [DW-1:0]        rdata
);
  logic [DW-1:0] rd_next;
  logic [N-1:0]  ctl_hit;
  logic          unused_bits;

  assign unused_bits = ^wdata[DW-1:CW+VW];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_hit
      assign ctl_hit[g] = (addr == ctl_addr(g));
    end
  endgenerate

  assign eoi_v    = wr_en && (addr == OFF_EOI);
  assign eoi_code = wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) level[i] <= '1;
      mask  <= '1;
      thr   <= '1;
      hold  <= 1'b0;
      vbase <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (ctl_hit[i]) begin
          level[i] <= wdata[PW-1:0];
          mask[i]  <= wdata[PW];
        end
      end
      case (addr)
        OFF_MASK: mask  <= wdata[N-1:0];
        OFF_THR:  thr   <= wdata[PW-1:0];
        OFF_STAT: hold  <= wdata[0];
        OFF_VEC:  vbase <= wdata[CW+VW-1:CW];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N; i++) begin
      if (ctl_hit[i]) begin
        rd_next[PW-1:0] = level[i];
        rd_next[PW]     = mask[i];
      end
    end
    case (addr)
      OFF_MASK: rd_next[N-1:0]     = mask;
      OFF_THR:  rd_next[PW-1:0]    = thr;
      OFF_STAT: rd_next[0]         = hold;
      OFF_VEC:  rd_next[CW+VW-1:CW] = vbase;
      OFF_PEND: rd_next[N-1:0]     = pend;
      OFF_INSV: rd_next[N-1:0]     = insv;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/slave_intc.sv
module slave_intc
  import slave_intc_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int PW = PRIO_W,
  parameter int VW = VBASE_W,
  parameter int CW = CODE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int IW = $clog2(N),
  localparam int TW = VW + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_en,
  input  logic [N-1:0]  src_req,
  input  logic          ack,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_out,
  output logic [TW-1:0] int_type
);
  logic [N-1:0]         req_q;
  logic [N-1:0]         inserv_q;
  logic [IW-1:0]        win_q;
  logic [N-1:0][PW-1:0] level;
  logic [N-1:0]         mask;
  logic [PW-1:0]        thr;
  logic                 hold;
  logic [VW-1:0]        vbase;
  logic                 eoi_v;
  logic [CW-1:0]        eoi_code;
  logic                 fire;
  logic [IW-1:0]        win_idx;
  logic                 take;
  logic [N-1:0]         take_vec;
  logic [N-1:0]         eoi_vec;
  logic [CW-1:0]        win_code;

  slave_intc_regs #(.N(N), .PW(PW), .VW(VW), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pend(req_q), .insv(inserv_q), .level(level),
    .mask(mask), .thr(thr), .hold(hold), .vbase(vbase), .eoi_v(eoi_v),
    .eoi_code(eoi_code), .rdata(rdata)
  );

  slave_intc_arb #(.N(N), .PW(PW)) u_arb (
    .pend(req_q), .insv(inserv_q), .mask(mask), .level(level), .thr(thr),
    .hold(hold), .enable(slave_en), .fire(fire), .win_idx(win_idx)
  );

  assign take = slave_en && ack && irq_out;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      assign take_vec[g] = take && (win_q == IW'(g));
      assign eoi_vec[g]  = eoi_v && (eoi_code == src_code(g));
    end
  endgenerate

  always_comb begin
    win_code = src_code(0);
    for (int i = 0; i < N; i++) begin
      if (win_idx == IW'(i)) win_code = src_code(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      inserv_q <= '0;
      win_q    <= '0;
      irq_out  <= 1'b0;
      int_type <= '0;
    end else begin
      req_q    <= (req_q & ~take_vec) | src_req;
      inserv_q <= (inserv_q & ~eoi_vec) | take_vec;
      irq_out  <= fire && !take;
      if (fire && !take) begin
        win_q    <= win_idx;
        int_type <= {vbase, win_code};
      end
    end
  end
endmodule

// File: rtl/slave_intc_chk.sv
module slave_intc_chk
  import slave_intc_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int TW = TYPE_W,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          slave_en,
  input logic          ack,
  input logic [N-1:0]  src_req,
  input logic          irq_out,
  input logic [TW-1:0] int_type,
  input logic [N-1:0]  req_q,
  input logic [N-1:0]  inserv_q,
  input logic [IW-1:0] win_q
);
  // R2
  master_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !slave_en |=> !irq_out);

  // R8
  ack_sets_insv_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_en && ack && irq_out) |=> inserv_q[$past(win_q)]);

  // R8
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_en && ack && irq_out) |=> !irq_out);

  // R4
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (int_type[2:0] != 3'b001 && int_type[2:0] < 3'b110));

  // R3
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_q & ~$past(req_q) & ~$past(src_req)) == '0));

  // R8
  insv_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((inserv_q & ~$past(inserv_q)) != '0) |-> $past(ack));
endmodule

bind slave_intc slave_intc_chk #(.N(N), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .slave_en(slave_en), .ack(ack), .src_req(src_req),
  .irq_out(irq_out), .int_type(int_type), .req_q(req_q),
  .inserv_q(inserv_q), .win_q(win_q)
);

// File: tb/slave_intc_tb.sv
module slave_intc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slave_en = 1'b0;
  logic [4:0]  src_req = '0;
  logic        ack = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  wire  [15:0] rdata;
  wire         irq_out;
  wire  [7:0]  int_type;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] rv;
  logic [4:0]  vb;

  always #10 clk = ~clk;

  slave_intc u_dut (
    .clk(clk), .rst(rst), .slave_en(slave_en), .src_req(src_req), .ack(ack),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_out(irq_out), .int_type(int_type)
  );

  function automatic logic [2:0] code_of(input int i);
    case (i)
      0: return 3'b000;
      1: return 3'b010;
      2: return 3'b011;
      3: return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    rv = rdata;
  endtask

  task automatic pulse(input logic [4:0] m);
    src_req = m;
    tick();
    src_req = '0;
  endtask

  task automatic ackp();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic set_ctl(input int i, input logic [2:0] lvl, input logic m);
    wr(8'(8'h32 + 2 * i), {12'h000, m, lvl});
  endtask

  task automatic eoi(input int i);
    wr(8'h22, {13'h0, code_of(i)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 irq", {15'h0, irq_out}, 16'h0);
    chk("R1 type", {8'h0, int_type}, 16'h0);
    for (int i = 0; i < 5; i++) begin
      rd(8'(8'h32 + 2 * i)); chk("R1 ctl", rv, 16'h000F);
    end
    rd(8'h28); chk("R1 mask", rv, 16'h001F);
    rd(8'h2A); chk("R1 thr", rv, 16'h0007);
    rd(8'h20); chk("R1 vec", rv, 16'h0000);
    rd(8'h2E); chk("R1 pend", rv, 16'h0000);
    rd(8'h2C); chk("R1 insv", rv, 16'h0000);

    // R2 master mode: no request, ack ignored, pending still latched (R3)
    set_ctl(0, 3'd0, 1'b0);
    pulse(5'b00001); tick();
    chk("R2 irq master", {15'h0, irq_out}, 16'h0);
    ackp();
    rd(8'h2C); chk("R2 insv master", rv, 16'h0000);
    rd(8'h2E); chk("R3 pend latched", rv, 16'h0001);
    slave_en = 1'b1; tick();
    chk("R2 irq slave", {15'h0, irq_out}, 16'h1);
    ackp();
    chk("R8 irq drop", {15'h0, irq_out}, 16'h0);
    rd(8'h2C); chk("R8 insv", rv, 16'h0001);
    rd(8'h2E); chk("R3 pend cleared", rv, 16'h0000);
    eoi(0);
    rd(8'h2C); chk("R10 eoi clear", rv, 16'h0000);
    set_ctl(0, 3'd7, 1'b1);

    // R4 sweep over sources and vector bases
    for (int v = 0; v < 3; v++) begin
      vb = (v == 0) ? 5'h00 : (v == 1) ? 5'h15 : 5'h1F;
      wr(8'h20, {8'h0, vb, 3'b111});
      rd(8'h20); chk("R4 vec read", rv, {8'h0, vb, 3'b000});
      for (int i = 0; i < 5; i++) begin
        set_ctl(i, 3'd0, 1'b0);
        pulse(5'(1 << i)); tick();
        chk("R4 irq", {15'h0, irq_out}, 16'h1);
        chk("R4 type", {8'h0, int_type}, {8'h0, vb, code_of(i)});
        ackp(); eoi(i);
        set_ctl(i, 3'd7, 1'b1);
      end
    end

    // R5 R8 R9 R10 rotation of priority assignment
    wr(8'h20, 16'h0); vb = '0;
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 5; k++) set_ctl(k, 3'((k + r) % 5), 1'b0);
      pulse(5'b11111); tick();
      for (int p = 0; p < 5; p++) begin
        int k;
        k = (p - r + 5) % 5;
        chk("R5 irq", {15'h0, irq_out}, 16'h1);
        chk("R5 winner", {8'h0, int_type}, {8'h0, vb, code_of(k)});
        ackp();
        chk("R8 irq low", {15'h0, irq_out}, 16'h0);
        tick();
        chk("R9 lower blocked", {15'h0, irq_out}, 16'h0);
        rd(8'h2C); chk("R8 insv bit", rv, 16'(1 << k));
        eoi(k); tick();
      end
      chk("R10 all done", {15'h0, irq_out}, 16'h0);
      rd(8'h2E); chk("R3 pend empty", rv, 16'h0000);
    end

    // R9 nesting with preemption
    for (int k = 0; k < 5; k++) set_ctl(k, 3'(k), 1'b0);
    pulse(5'b01000); tick();
    chk("R9 first", {8'h0, int_type}, {8'h0, vb, 3'b100});
    ackp();
    pulse(5'b10000); tick();
    chk("R9 lower held", {15'h0, irq_out}, 16'h0);
    pulse(5'b00010); tick();
    chk("R9 preempt irq", {15'h0, irq_out}, 16'h1);
    chk("R9 preempt type", {8'h0, int_type}, {8'h0, vb, 3'b010});
    ackp();
    rd(8'h2C); chk("R8 nested insv", rv, 16'h000A);
    wr(8'h22, 16'h0001);
    rd(8'h2C); chk("R10 unused code", rv, 16'h000A);
    rd(8'h22); chk("R10 reads zero", rv, 16'h0000);
    eoi(1); tick();
    chk("R9 still nested", {15'h0, irq_out}, 16'h0);
    rd(8'h2C); chk("R10 specific", rv, 16'h0008);
    eoi(3); tick();
    chk("R9 released", {8'h0, int_type}, {8'h0, vb, 3'b101});
    chk("R9 released irq", {15'h0, irq_out}, 16'h1);
    ackp(); eoi(4); tick();
    chk("R10 idle", {15'h0, irq_out}, 16'h0);

    // R6 mask mirror
    wr(8'h28, 16'h0004);
    rd(8'h32); chk("R6 ctl0 mirror", rv, 16'h0000);
    rd(8'h36); chk("R6 ctl2 mirror", rv, 16'h000A);
    pulse(5'b00100); tick();
    chk("R6 masked", {15'h0, irq_out}, 16'h0);
    set_ctl(2, 3'd2, 1'b0);
    rd(8'h28); chk("R6 reg mirror", rv, 16'h0000);
    chk("R6 unmasked", {8'h0, int_type}, {8'h0, vb, 3'b011});
    chk("R6 unmasked irq", {15'h0, irq_out}, 16'h1);
    ackp(); eoi(2); tick();

    // R7 threshold
    wr(8'h2A, 16'h0002);
    pulse(5'b01000); tick();
    chk("R7 blocked", {15'h0, irq_out}, 16'h0);
    rd(8'h2E); chk("R3 pend kept", rv, 16'h0008);
    wr(8'h2A, 16'h0003); tick();
    chk("R7 passes", {8'h0, int_type}, {8'h0, vb, 3'b100});
    chk("R7 passes irq", {15'h0, irq_out}, 16'h1);
    ackp(); eoi(3); wr(8'h2A, 16'h0007);

    // R11 hold
    wr(8'h30, 16'h0001);
    pulse(5'b00001); tick();
    chk("R11 held", {15'h0, irq_out}, 16'h0);
    rd(8'h30); chk("R11 read", rv, 16'h0001);
    rd(8'h2E); chk("R11 pend kept", rv, 16'h0001);
    wr(8'h30, 16'h0000); tick();
    chk("R11 released", {15'h0, irq_out}, 16'h1);
    ackp(); eoi(0); tick();
    chk("R11 idle", {15'h0, irq_out}, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule